// File: doc/BRIEF.md
# Banked Memory Bridge for a 16-bit-Address CPU

This block sits between a CPU with a 16-bit address bus and three targets: a 1 MB SRAM, a boot ROM and a single I/O window. The CPU puts a bank number on its data bus while the clock phase `phi2` is low. The bridge keeps the low nibble of that byte and uses it as address lines 16 to 19. When `phi2` rises the bank is frozen for the rest of the cycle. The bridge then decodes the full 20-bit address into one of three selects.

The bridge also times the SRAM strobes and steers data in both directions. Each tristate bus is modelled as a separate input, output and output-enable, so a bench can watch every bus phase without bidirectional nets. Reading data from RAM and writing data to RAM both happen only while `phi2` is high. During the low phase the CPU drives its bank byte, and nothing in the bridge drives against it.

A parameter builds a bank-0-only variant. In that variant the extended address is tied to zero and the bank byte is ignored. The interface is a plain synchronous bus with no handshake, so no valid/ready back-pressure applies.

Top module: `glue_mem_bridge`

## Requirements
- R1: While `phi2` is low and reset is inactive, `ext_addr` follows `cpu_din[3:0]` combinationally.
- R2: On the rising edge of `phi2`, `ext_addr` takes the value of `cpu_din[3:0]` at that edge. It holds that value for the whole high phase, even when `cpu_din` changes afterwards.
- R3: Exactly one of `rom_sel`, `ram_sel` and `io_sel` is high. The map uses the 20-bit address {`ext_addr`, `cpu_addr`}:
  - `rom_sel` covers bank 0 at $E000-$FFFF.
  - `io_sel` covers bank 0 at $DF00-$DFFF.
  - `ram_sel` covers every other address.
- R4: `rw` = 1 means read and `rw` = 0 means write. `ram_we_n` is low only while `phi2` is high, `ram_sel` is high and `rw` = 0.
- R5: `ram_oe_n` is low only while `phi2` is high, `ram_sel` is high and `rw` = 1. It is never low at the same time as `ram_we_n`.
- R6: `cpu_doe` is high exactly when `phi2`, `ram_sel` and `rw` are all high. While it is high, `cpu_dout` equals `ram_din`; otherwise `cpu_dout` is 0.
- R7: `ram_doe` is high exactly when `phi2` and `ram_sel` are high and `rw` = 0. While it is high, `ram_dout` equals `cpu_din`; otherwise `ram_dout` is 0.
- R8: With `BANK0_ONLY` = 1, `ext_addr` is always 0 and decoding treats every access as bank 0, whatever the data bus carries.
- R9: While `rst_n` is low, the following all hold in both phases:
  - the stored bank is cleared and `ext_addr` is 0;
  - `ram_we_n` and `ram_oe_n` are 1;
  - both data paths are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | CPU clock phase; high half carries data |
| rst_n | input | 1 | Active-low asynchronous reset |
| rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | Byte the CPU drives (bank byte in low phase, write data in high phase) |
| cpu_dout | output | 8 | Byte driven toward the CPU on RAM reads |
| cpu_doe | output | 1 | Enable for the RAM-to-CPU path |
| ext_addr | output | 4 | Extended address lines 16-19 |
| rom_sel | output | 1 | Boot ROM select, active high |
| ram_sel | output | 1 | SRAM select, active high |
| io_sel | output | 1 | I/O window select, active high |
| ram_oe_n | output | 1 | SRAM output enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |
| ram_din | input | 8 | Byte driven by the SRAM |
| ram_dout | output | 8 | Byte driven toward the SRAM on writes |
| ram_doe | output | 1 | Enable for the CPU-to-RAM path |

## Verification
A corrupted stored bank shows up at `ext_addr` and on the selects within the same high phase: a RAM access moves to the wrong 64 KB page, or falls into or out of the ROM or I/O window. Such errors show only in the high phase, so the bench changes the data bus after the rising edge and compares `ext_addr` with the byte seen at that edge. A wrong strobe or path enable shows up within one phase: a write or a RAM drive during the low phase would contend with the bank byte. The bench therefore checks both phases of every cycle over all banks, all region boundaries and both directions.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_ROM = 2'd1,
    RGN_IO  = 2'd2
  } region_e;
endpackage

// File: rtl/glue_bank_latch.sv
// Bank capture: transparent in the low phase, held during the high phase.
module glue_bank_latch #(
  parameter int BANK_W     = 4,
  parameter bit BANK0_ONLY = 1'b0
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_in,
  output logic [BANK_W-1:0] bank_out
);
  generate
    if (BANK0_ONLY) begin : g_fixed
      assign bank_out = '0;
    end else begin : g_capture
      logic [BANK_W-1:0] held_q;
      always_ff @(posedge phi2 or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= bank_in;
      end
      // low phase: pass through; high phase: value frozen at the rising edge
      assign bank_out = !rst_n ? '0 : (phi2 ? held_q : bank_in);
    end
  endgenerate
endmodule

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
  import glue_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                BANK_W = 4,
  parameter logic [ADDR_W-1:0] ROM_LO = 16'hE000,
  parameter logic [ADDR_W-1:0] IO_LO  = 16'hDF00,
  parameter logic [ADDR_W-1:0] IO_HI  = 16'hDFFF
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    region = RGN_RAM;
    if (bank == '0) begin
      if (addr >= ROM_LO)                     region = RGN_ROM;
      else if (addr >= IO_LO && addr <= IO_HI) region = RGN_IO;
    end
  end
endmodule

// File: rtl/glue_data_path.sv
// Two one-way bus paths and the SRAM strobes, all qualified by the high phase.
module glue_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              ram_hit,
  input  logic              rw,
  input  logic [DATA_W-1:0] cpu_din,
  input  logic [DATA_W-1:0] ram_din,
  output logic [DATA_W-1:0] cpu_dout,
  output logic              cpu_doe,
  output logic [DATA_W-1:0] ram_dout,
  output logic              ram_doe,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  logic live;
  logic rd_phase;
  logic wr_phase;

  assign live     = rst_n & phi2 & ram_hit;
  assign rd_phase = live &  rw;
  assign wr_phase = live & ~rw;

  assign cpu_doe  = rd_phase;
  assign ram_doe  = wr_phase;
  assign ram_oe_n = ~rd_phase;
  assign ram_we_n = ~wr_phase;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      assign cpu_dout[b] = rd_phase & ram_din[b];
      assign ram_dout[b] = wr_phase & cpu_din[b];
    end
  endgenerate
endmodule

// File: rtl/glue_mem_bridge.sv
module glue_mem_bridge
  import glue_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                BANK_W     = 4,
  parameter logic [ADDR_W-1:0] ROM_LO     = 16'hE000,
  parameter logic [ADDR_W-1:0] IO_LO      = 16'hDF00,
  parameter logic [ADDR_W-1:0] IO_HI      = 16'hDFFF,
  parameter bit                BANK0_ONLY = 1'b0
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_din,
  output logic [DATA_W-1:0] cpu_dout,
  output logic              cpu_doe,
  output logic [BANK_W-1:0] ext_addr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              io_sel,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  input  logic [DATA_W-1:0] ram_din,
  output logic [DATA_W-1:0] ram_dout,
  output logic              ram_doe
);
  region_e region;

  glue_bank_latch #(
    .BANK_W     (BANK_W),
    .BANK0_ONLY (BANK0_ONLY)
  ) u_bank (
    .phi2     (phi2),
    .rst_n    (rst_n),
    .bank_in  (cpu_din[BANK_W-1:0]),
    .bank_out (ext_addr)
  );

  glue_addr_decode #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .ROM_LO (ROM_LO),
    .IO_LO  (IO_LO),
    .IO_HI  (IO_HI)
  ) u_dec (
    .bank   (ext_addr),
    .addr   (cpu_addr),
    .region (region)
  );

  assign rom_sel = (region == RGN_ROM);
  assign io_sel  = (region == RGN_IO);
  assign ram_sel = (region == RGN_RAM);

  glue_data_path #(
    .DATA_W (DATA_W)
  ) u_path (
    .phi2     (phi2),
    .rst_n    (rst_n),
    .ram_hit  (ram_sel),
    .rw       (rw),
    .cpu_din  (cpu_din),
    .ram_din  (ram_din),
    .cpu_dout (cpu_dout),
    .cpu_doe  (cpu_doe),
    .ram_dout (ram_dout),
    .ram_doe  (ram_doe),
    .ram_oe_n (ram_oe_n),
    .ram_we_n (ram_we_n)
  );
endmodule

// File: rtl/glue_mem_bridge_chk.sv
module glue_mem_bridge_chk #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                BANK_W     = 4,
  parameter logic [ADDR_W-1:0] ROM_LO     = 16'hE000,
  parameter logic [ADDR_W-1:0] IO_LO      = 16'hDF00,
  parameter logic [ADDR_W-1:0] IO_HI      = 16'hDFFF,
  parameter bit                BANK0_ONLY = 1'b0
) (
  input logic              phi2,
  input logic              rst_n,
  input logic              rw,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_din,
  input logic [DATA_W-1:0] cpu_dout,
  input logic              cpu_doe,
  input logic [BANK_W-1:0] ext_addr,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic              io_sel,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic [DATA_W-1:0] ram_din,
  input logic [DATA_W-1:0] ram_dout,
  input logic              ram_doe
);
  logic [BANK_W-1:0] edge_bank_q;
  logic              edge_seen_q;

  always_ff @(posedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      edge_bank_q <= '0;
      edge_seen_q <= 1'b0;
    end else begin
      edge_bank_q <= cpu_din[BANK_W-1:0];
      edge_seen_q <= 1'b1;
    end
  end

  // R2
  bank_hold_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    edge_seen_q |-> ext_addr == ((BANK0_ONLY != 1'b0) ? {BANK_W{1'b0}} : edge_bank_q));

  // R4
  low_phase_quiet_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    ram_we_n && ram_oe_n && !cpu_doe && !ram_doe);

  // R5
  strobe_excl_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    !(!ram_oe_n && !ram_we_n));

  // R3
  one_select_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    $countones({rom_sel, ram_sel, io_sel}) == 1);

  // R3
  io_window_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    io_sel |-> (ext_addr == '0 && cpu_addr >= IO_LO && cpu_addr <= IO_HI));

  // R3
  rom_window_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    rom_sel |-> (ext_addr == '0 && cpu_addr >= ROM_LO));

  // R4
  write_qual_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    !ram_we_n |-> (ram_sel && !rw));

  // R6
  read_path_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    cpu_doe |-> (cpu_dout == ram_din && !ram_oe_n));

  // R7
  write_path_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    ram_doe |-> (ram_dout == cpu_din && !ram_we_n));
endmodule

bind glue_mem_bridge glue_mem_bridge_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BANK_W     (BANK_W),
  .ROM_LO     (ROM_LO),
  .IO_LO      (IO_LO),
  .IO_HI      (IO_HI),
  .BANK0_ONLY (BANK0_ONLY)
) u_chk (.*);

// File: tb/glue_mem_bridge_tb.sv
module glue_mem_bridge_tb;
  logic        phi2 = 1'b0;
  logic        rst_n = 1'b0;
  logic        rw = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  rdin = '0;

  logic [7:0] cpu_dout, ram_dout, cpu_dout0, ram_dout0;
  logic [3:0] ext, ext0;
  logic cpu_doe, ram_doe, rom_sel, ram_sel, io_sel, oe_n, we_n;
  logic cpu_doe0, ram_doe0, rom_sel0, ram_sel0, io_sel0, oe_n0, we_n0;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #10 phi2 = ~phi2;

  glue_mem_bridge u_dut (
    .phi2(phi2), .rst_n(rst_n), .rw(rw), .cpu_addr(addr), .cpu_din(din),
    .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .ext_addr(ext),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .io_sel(io_sel),
    .ram_oe_n(oe_n), .ram_we_n(we_n), .ram_din(rdin),
    .ram_dout(ram_dout), .ram_doe(ram_doe)
  );

  glue_mem_bridge #(.BANK0_ONLY(1'b1)) u_dut_b0 (
    .phi2(phi2), .rst_n(rst_n), .rw(rw), .cpu_addr(addr), .cpu_din(din),
    .cpu_dout(cpu_dout0), .cpu_doe(cpu_doe0), .ext_addr(ext0),
    .rom_sel(rom_sel0), .ram_sel(ram_sel0), .io_sel(io_sel0),
    .ram_oe_n(oe_n0), .ram_we_n(we_n0), .ram_din(rdin),
    .ram_dout(ram_dout0), .ram_doe(ram_doe0)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_at(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h1234;
      2: return 16'hDEFF;
      3: return 16'hDF00;
      4: return 16'hDF80;
      5: return 16'hDFFF;
      6: return 16'hE000;
      default: return 16'hFFFF;
    endcase
  endfunction

  // {rom, ram, io}
  function automatic logic [2:0] exp_sel(input logic [3:0] b, input logic [15:0] a);
    if (b == 4'h0 && a >= 16'hE000) return 3'b100;
    if (b == 4'h0 && a >= 16'hDF00 && a <= 16'hDFFF) return 3'b001;
    return 3'b010;
  endfunction

  task automatic bus_cycle(input logic [3:0] bank, input logic [15:0] a, input logic r);
    logic [2:0] s, s0;
    logic       hit, hit0;
    s    = exp_sel(bank, a);
    s0   = exp_sel(4'h0, a);
    hit  = s[1];
    hit0 = s0[1];
    @(negedge phi2);
    #2;
    addr = a; rw = r; din = {4'hC, bank}; rdin = a[7:0] ^ 8'h96;
    #5;
    check("R1", "ext_addr low phase", ext, bank);
    check("R8", "bank0 ext_addr low phase", ext0, 4'h0);
    check("R4", "we_n low phase", we_n, 1'b1);
    check("R5", "oe_n low phase", oe_n, 1'b1);
    check("R6", "cpu_doe low phase", cpu_doe, 1'b0);
    check("R7", "ram_doe low phase", ram_doe, 1'b0);
    @(posedge phi2);
    #2;
    din = {bank, ~bank};
    #5;
    check("R2", "ext_addr held", ext, bank);
    check("R3", "selects", {rom_sel, ram_sel, io_sel}, s);
    check("R4", "we_n", we_n, !(hit && !r));
    check("R5", "oe_n", oe_n, !(hit && r));
    check("R6", "cpu_doe", cpu_doe, hit && r);
    check("R6", "cpu_dout", cpu_dout, (hit && r) ? rdin : 8'h00);
    check("R7", "ram_doe", ram_doe, hit && !r);
    check("R7", "ram_dout", ram_dout, (hit && !r) ? din : 8'h00);
    check("R8", "bank0 ext_addr", ext0, 4'h0);
    check("R8", "bank0 selects", {rom_sel0, ram_sel0, io_sel0}, s0);
    check("R8", "bank0 we_n", we_n0, !(hit0 && !r));
  endtask

  initial begin
    // R9: reset held across one full cycle with a RAM write address
    @(negedge phi2);
    #2;
    addr = 16'h1234; rw = 1'b0; din = 8'hC5;
    #5;
    check("R9", "ext_addr in reset low", ext, 4'h0);
    @(posedge phi2);
    #7;
    check("R9", "ext_addr in reset high", ext, 4'h0);
    check("R9", "we_n in reset", we_n, 1'b1);
    check("R9", "oe_n in reset", oe_n, 1'b1);
    check("R9", "ram_doe in reset", ram_doe, 1'b0);
    check("R9", "cpu_doe in reset", cpu_doe, 1'b0);
    @(negedge phi2);
    #1 rst_n = 1'b1;

    for (int b = 0; b < 16; b++)
      for (int i = 0; i < 8; i++)
        for (int r = 0; r < 2; r++)
          bus_cycle(4'(b), addr_at(i), r[0]);

    // R9: reset asserted mid high phase clears the held bank at once
    @(posedge phi2);
    #3 rst_n = 1'b0;
    #2;
    check("R9", "ext_addr after async reset", ext, 4'h0);
    check("R9", "we_n after async reset", we_n, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule